// File: doc/BRIEF.md
# Deep Standby Controller with Stabilized Wakeup

This block decides when a small processor may drop into its deepest low-power state, and brings it back out safely. Standby is entered only when the software has armed it through three configuration bits and the core then executes its sleep instruction. In standby both the oscillator enable and the internal clock enable are held low.

An interrupt request wakes the block. A bus request can also wake it, but only when the bus-exit enable is set. Waking first restarts the oscillator. A counter then times a fixed stabilization interval, 131072 cycles by default. The wake source must stay asserted for the whole interval. If it drops early, the block goes back to standby and turns the oscillator off again.

When the interval completes, an interrupt wake resumes the clocks and sends a one-cycle acknowledge pulse. A bus wake resumes the clocks and turns off the address and bus-control drivers. It then grants the bus. When the bus request is released, it re-enables the drivers, forces them high for one cycle and returns to normal running.

Top module: `standby_ctl`

## Requirements
- R1: Standby is entered on the clock edge after `sleepStrobe` is high only when all three of these hold: `stbyArm`=1, `haltSel`=0 and `ioStopArm`=1. If any one of them fails, the block stays in run.
- R2: In standby, `oscEn` and `clkEn` are both 0.
- R3: `irqReq` high in standby starts stabilization. During the STAB_COUNT cycles of stabilization, `oscEn` is 1 and `clkEn` is 0. On the next cycle `clkEn` returns to 1 and `irqAck` is high for exactly one cycle.
- R4: If the wake source falls before the interval ends, the block returns to standby on the next edge, with `oscEn` at 0.
- R5: While `busExitEn`=0, `busReq` has no effect in standby, and the block stays in standby.
- R6: After a bus wake completes its interval, the block spends one cycle with `addrDrvEn`=`ctlDrvEn`=0 and `busAck`=0. After that cycle, `busAck` goes to 1 while both driver enables stay at 0.
- R7: When `busReq` falls during the grant, the next cycle has `busAck`=0, both driver enables at 1 and a one-cycle `busHighDrive` pulse. The block is then in run.
- R8: `status` encoding is 0 = run, 1 = standby, 2 = stabilizing, 3 = bus granted. Code 3 also covers the driver-off cycle before the grant.
- R9: After reset the block is in run: `oscEn`=1, `clkEn`=1, both driver enables are 1, and `busAck`, `irqAck` and `busHighDrive` are 0.
- R10: If `irqReq` and an enabled `busReq` are both high when standby is left, the interrupt path wins. The block ends in run with `irqAck` and never grants the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the always-on domain |
| rstN | input | 1 | Asynchronous active-low reset |
| stbyArm | input | 1 | Standby-arm configuration bit (must be 1) |
| haltSel | input | 1 | Halt-select configuration bit (must be 0) |
| ioStopArm | input | 1 | Peripheral-stop bit (must be 1) |
| busExitEn | input | 1 | Lets bus request wake from standby |
| sleepStrobe | input | 1 | One-cycle pulse when the sleep instruction executes |
| irqReq | input | 1 | External interrupt request |
| busReq | input | 1 | External bus request |
| oscEn | output | 1 | Oscillator enable |
| clkEn | output | 1 | Internal clock enable |
| irqAck | output | 1 | One-cycle interrupt wake acknowledge |
| busAck | output | 1 | Bus grant |
| addrDrvEn | output | 1 | Address bus driver enable |
| ctlDrvEn | output | 1 | Memory, I/O, read and write strobe driver enable |
| busHighDrive | output | 1 | One-cycle pulse driving released bus lines high |
| status | output | 2 | Current state code |

## Verification
The hardest case to reach from the ports is an aborted wakeup. The wake source has to fall partway through the stabilization interval, and the block must drop straight back to standby rather than finishing the interval. The bench builds the block with a short interval. It raises the interrupt from standby, then releases it a known number of edges later. It expects standby on the following edge and for a full interval after that. The bench handles the lost arbitration between interrupt and enabled bus request the same way: it raises both in the same cycle and checks that no grant follows.

// File: rtl/standby_pkg.sv
package standby_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_STAB,
    ST_FLOAT,
    ST_GRANT
  } pwrState_t;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } cntCtl_t;

  localparam logic [1:0] STAT_RUN   = 2'd0;
  localparam logic [1:0] STAT_SLEEP = 2'd1;
  localparam logic [1:0] STAT_STAB  = 2'd2;
  localparam logic [1:0] STAT_BUS   = 2'd3;

endpackage

// File: rtl/stby_counter.sv
module stby_counter
  import standby_pkg::*;
#(
  parameter int STAB_COUNT = 131072
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCtl_t ctl,
  output logic    termHit
);

  localparam int CNT_W = $clog2(STAB_COUNT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_COUNT - 1);

  logic [CNT_W-1:0] cnt;

  assign termHit = ctl.cntStep && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntClear) begin
      cnt <= '0;
    end else if (ctl.cntStep && !termHit) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST); // R3

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntClear |=> (cnt == '0)); // R4

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import standby_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stbyArm,
  input  logic       haltSel,
  input  logic       ioStopArm,
  input  logic       busExitEn,
  input  logic       sleepStrobe,
  input  logic       irqReq,
  input  logic       busReq,
  input  logic       termHit,
  output cntCtl_t    cntCtl,
  output logic       oscEn,
  output logic       clkEn,
  output logic       irqAck,
  output logic       busAck,
  output logic       addrDrvEn,
  output logic       ctlDrvEn,
  output logic       busHighDrive,
  output logic [1:0] status
);

  pwrState_t state, stateNext;
  logic srcBus, srcBusNext;
  logic ackNext, hiNext;
  logic sleepReq, srcHeld;

  assign sleepReq = sleepStrobe && stbyArm && !haltSel && ioStopArm;
  assign srcHeld  = srcBus ? busReq : irqReq;

  always_comb begin
    stateNext  = state;
    srcBusNext = srcBus;
    ackNext    = 1'b0;
    hiNext     = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (sleepReq) stateNext = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (irqReq) begin
          stateNext  = ST_STAB;
          srcBusNext = 1'b0;
        end else if (busReq && busExitEn) begin
          stateNext  = ST_STAB;
          srcBusNext = 1'b1;
        end
      end
      ST_STAB: begin
        if (!srcHeld) begin
          stateNext = ST_SLEEP;
        end else if (termHit) begin
          stateNext = srcBus ? ST_FLOAT : ST_RUN;
          ackNext   = !srcBus;
        end
      end
      ST_FLOAT: stateNext = ST_GRANT;
      ST_GRANT: begin
        if (!busReq) begin
          stateNext = ST_RUN;
          hiNext    = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_RUN;
      srcBus       <= 1'b0;
      irqAck       <= 1'b0;
      busHighDrive <= 1'b0;
    end else begin
      state        <= stateNext;
      srcBus       <= srcBusNext;
      irqAck       <= ackNext;
      busHighDrive <= hiNext;
    end
  end

  always_comb begin
    cntCtl.cntStep  = (state == ST_STAB);
    cntCtl.cntClear = (state != ST_STAB);
    oscEn     = (state != ST_SLEEP);
    clkEn     = (state == ST_RUN) || (state == ST_FLOAT) || (state == ST_GRANT);
    busAck    = (state == ST_GRANT);
    addrDrvEn = !((state == ST_FLOAT) || (state == ST_GRANT));
    ctlDrvEn  = addrDrvEn;
    unique case (state)
      ST_RUN:   status = STAT_RUN;
      ST_SLEEP: status = STAT_SLEEP;
      ST_STAB:  status = STAT_STAB;
      default:  status = STAT_BUS;
    endcase
  end

  AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP) |-> (!oscEn && !clkEn)); // R2

  AST_ACK_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> $past(termHit)); // R3

  AST_ABORT_TO_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STAB && !srcHeld) |=> (state == ST_SLEEP)); // R4

  AST_IGNORE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !irqReq && !busExitEn) |=> (state == ST_SLEEP)); // R5

  AST_FLOAT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && !$past(busAck)) |-> ($past(!addrDrvEn) && !addrDrvEn)); // R6

  AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busHighDrive |-> (!busAck && addrDrvEn && $past(busAck))); // R7

endmodule

// File: rtl/standby_ctl.sv
module standby_ctl
  import standby_pkg::*;
#(
  parameter int STAB_COUNT = 131072
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stbyArm,
  input  logic       haltSel,
  input  logic       ioStopArm,
  input  logic       busExitEn,
  input  logic       sleepStrobe,
  input  logic       irqReq,
  input  logic       busReq,
  output logic       oscEn,
  output logic       clkEn,
  output logic       irqAck,
  output logic       busAck,
  output logic       addrDrvEn,
  output logic       ctlDrvEn,
  output logic       busHighDrive,
  output logic [1:0] status
);

  cntCtl_t cntCtl;
  logic    termHit;

  stby_fsm u_fsm (
    .clk(clk), .rstN(rstN),
    .stbyArm(stbyArm), .haltSel(haltSel), .ioStopArm(ioStopArm),
    .busExitEn(busExitEn), .sleepStrobe(sleepStrobe),
    .irqReq(irqReq), .busReq(busReq), .termHit(termHit),
    .cntCtl(cntCtl), .oscEn(oscEn), .clkEn(clkEn), .irqAck(irqAck),
    .busAck(busAck), .addrDrvEn(addrDrvEn), .ctlDrvEn(ctlDrvEn),
    .busHighDrive(busHighDrive), .status(status)
  );

  stby_counter #(.STAB_COUNT(STAB_COUNT)) u_cnt (
    .clk(clk), .rstN(rstN), .ctl(cntCtl), .termHit(termHit)
  );

endmodule

// File: tb/sim_standby_ctl.sv
module sim_standby_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  typedef struct {
    int         cyc;
    string      tag;
    logic [8:0] val;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stbyArm = 0, haltSel = 0, ioStopArm = 0, busExitEn = 0;
  logic sleepStrobe = 0, irqReq = 0, busReq = 0;
  logic oscEn, clkEn, irqAck, busAck, addrDrvEn, ctlDrvEn, busHighDrive;
  logic [1:0] status;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  expItem_t q[$];

  standby_ctl #(.STAB_COUNT(N)) u0 (
    .clk(clk), .rstN(rstN), .stbyArm(stbyArm), .haltSel(haltSel),
    .ioStopArm(ioStopArm), .busExitEn(busExitEn), .sleepStrobe(sleepStrobe),
    .irqReq(irqReq), .busReq(busReq), .oscEn(oscEn), .clkEn(clkEn),
    .irqAck(irqAck), .busAck(busAck), .addrDrvEn(addrDrvEn),
    .ctlDrvEn(ctlDrvEn), .busHighDrive(busHighDrive), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] mk(input logic [1:0] st, input logic osc,
      input logic ce, input logic ia, input logic ba, input logic drv,
      input logic hi);
    return {st, osc, ce, ia, ba, drv, drv, hi};
  endfunction

  // status 0 run, 1 standby, 2 stabilizing, 3 bus granted (R8)
  localparam logic [8:0] V_RUN   = {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [8:0] V_SLEEP = {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [8:0] V_STAB  = {2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [8:0] V_WAKE  = {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [8:0] V_FLOAT = {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [8:0] V_GRANT = {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [8:0] V_REL   = {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  task automatic expectAt(input int k, input logic [8:0] v, input string tag);
    q.push_back('{cyc + k, tag, v});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic goSleep(input string tag);
    stbyArm = 1; haltSel = 0; ioStopArm = 1; sleepStrobe = 1;
    expectAt(1, V_SLEEP, tag);
    step(1);
    sleepStrobe = 0;
  endtask

  task automatic tryBadEntry(input logic a, input logic h, input logic s);
    stbyArm = a; haltSel = h; ioStopArm = s; sleepStrobe = 1;
    expectAt(1, V_RUN, "R1 entry refused");
    step(1);
    sleepStrobe = 0;
    stbyArm = 0; haltSel = 0; ioStopArm = 0;
  endtask

  // monitor: pops expectations due this cycle and compares
  always @(negedge clk) begin
    logic [8:0] got;
    #1;
    got = {status, oscEn, clkEn, irqAck, busAck, addrDrvEn, ctlDrvEn, busHighDrive};
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      expItem_t it;
      it = q.pop_front();
      checks++;
      if (it.cyc != cyc) begin
        errors++;
        $display("FAIL %s: missed sample at cycle %0d (now %0d)", it.tag, it.cyc, cyc);
      end else if (got !== it.val) begin
        errors++;
        $display("FAIL %s: cycle %0d got %b expected %b", it.tag, cyc, got, it.val);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1;
    expectAt(1, V_RUN, "R9 reset state");
    step(2);

    // R1: each missing condition blocks entry
    tryBadEntry(1'b0, 1'b0, 1'b1);
    tryBadEntry(1'b1, 1'b1, 1'b1);
    tryBadEntry(1'b1, 1'b0, 1'b0);
    stbyArm = 1; haltSel = 0; ioStopArm = 1;
    expectAt(1, V_RUN, "R1 no strobe");
    step(1);

    goSleep("R1 R2 R8 entry");

    // R5: bus request ignored with exit disabled
    busExitEn = 0; busReq = 1;
    expectAt(1, V_SLEEP, "R5");
    expectAt(N + 2, V_SLEEP, "R5");
    step(N + 3);
    busReq = 0;
    step(1);

    // R3: interrupt wake
    irqReq = 1;
    expectAt(1, V_STAB, "R3 stab start");
    expectAt(N, V_STAB, "R3 stab end");
    expectAt(N + 1, V_WAKE, "R3 wake ack");
    expectAt(N + 2, V_RUN, "R3 ack pulse");
    step(N + 2);
    irqReq = 0;
    step(1);

    // R4: aborted wake
    goSleep("R2 reentry");
    irqReq = 1;
    expectAt(3, V_STAB, "R4 mid count");
    expectAt(4, V_SLEEP, "R4 abort");
    expectAt(N + 6, V_SLEEP, "R4 stays");
    step(3);
    irqReq = 0;
    step(N + 4);

    // R6 R7: bus wake, grant, release
    busExitEn = 1; busReq = 1;
    expectAt(1, V_STAB, "R6 stab");
    expectAt(N + 1, V_FLOAT, "R6 drivers off");
    expectAt(N + 2, V_GRANT, "R6 grant");
    expectAt(N + 5, V_GRANT, "R6 grant held");
    step(N + 5);
    busReq = 0;
    expectAt(1, V_REL, "R7 release");
    expectAt(2, V_RUN, "R7 run");
    step(3);

    // R10: interrupt wins over enabled bus request
    goSleep("R8 standby code");
    busExitEn = 1; irqReq = 1; busReq = 1;
    expectAt(N + 1, V_WAKE, "R10 irq wins");
    expectAt(N + 2, V_RUN, "R10 no grant");
    step(N + 3);
    irqReq = 0; busReq = 0;

    step(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule